// File: doc/BRIEF.md
# Four-Mode Addressable Latch Demultiplexer

This block keeps eight output bits and steers a single data bit onto them under control of a binary address and two active-low controls, `en_n` and `clr_n`. The two controls choose one of four modes:

- **Hold**: nothing changes.
- **Addressable write**: only the selected bit takes the data value.
- **One-of-eight demultiplex**: the selected bit carries the data and every other bit is forced low.
- **Clear**: every bit goes low.

The model is clocked and has no latches. Eight flip-flops are loaded on each rising edge according to the mode sampled there, and the outputs come straight from those flip-flops.

Wider storage is built by placing several copies side by side. A higher-order address decode drives each copy's `en_n`, and data and clear are shared between them. Address changes are meant to happen while the block holds. A watcher raises a one-cycle `addr_err` flag when, with enable active, the sampled address moves by more than one bit between two consecutive edges.

Top module: `addrlatch_demux`

## Requirements
- R1: While `rst_n` is low at a rising edge, `q` becomes all zeros and `addr_err` becomes low after that edge, whatever `clr_n`, `en_n`, `addr` and `d` are.
- R2: With `en_n`=1 and `clr_n`=1 (hold), `q` after the edge equals `q` before it for any `addr` and `d`.
- R3: With `en_n`=0 and `clr_n`=1 (write), bit `q[addr]` takes `d` and all other bits keep their values.
- R4: With `en_n`=0 and `clr_n`=0 (demultiplex), `q[addr]` takes `d` and all other bits become 0.
- R5: With `en_n`=1 and `clr_n`=0 (clear), `q` becomes all zeros for any `addr` and `d`.
- R6: `addr` is plain binary with `addr[0]` least significant: value k selects `q[k]` (1 selects `q[1]`, 7 selects `q[7]`).
- R7: `q` does not change between edges. A new mode or input shows on `q` only after the next rising edge.
- R8: The pattern left by demultiplex mode is the starting state for any following hold or write.
- R9: `addr_err` is high for the one cycle after an edge where `en_n`=0 and `addr` differs in two or more bit positions from the value sampled at the previous edge. It stays low for single-bit changes, when `en_n`=1, and at the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| addr | input | ADDR_W (3) | Binary bit select, bit 0 least significant |
| d | input | 1 | Data bit |
| q | output | 2**ADDR_W (8) | Stored outputs |
| addr_err | output | 1 | One-cycle flag for a multi-bit address change while enabled |

## Verification
A corrupted storage bit stays visible on `q` from the next edge onward. It remains wrong through hold and write modes until that exact bit is addressed, cleared or demultiplexed away. That is why the bench compares every cycle against a reference model rather than only at the end.

A wrong mode decode shows one edge after the mode is applied, as bits that were kept but should have been cleared, or the reverse. A stale previous-address register in the watcher shows as an `addr_err` pulse one cycle after a move that is really a single-bit change, or as a missing pulse after a multi-bit move.

// File: rtl/addrlatch_pkg.sv
package addrlatch_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;

  // Map the two active-low controls onto a mode.
  function automatic mode_e decode_mode(input logic en_n, input logic clr_n);
    mode_e m;
    case ({en_n, clr_n})
      2'b11:   m = MODE_HOLD;
      2'b01:   m = MODE_WRITE;
      2'b00:   m = MODE_DEMUX;
      default: m = MODE_CLEAR;
    endcase
    return m;
  endfunction

  // True when two or more bits of the difference word are set.
  function automatic logic multi_bit(input logic [31:0] diff);
    return (diff & (diff - 32'd1)) != 32'd0;
  endfunction

endpackage

// File: rtl/addrlatch_sel_dec.sv
module addrlatch_sel_dec #(
  parameter int ADDR_W = 3,
  localparam int N_OUT = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_OUT-1:0]  sel
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/addrlatch_store.sv
module addrlatch_store
  import addrlatch_pkg::*;
#(
  parameter int N_OUT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic [N_OUT-1:0] sel,
  input  logic             d,
  output logic [N_OUT-1:0] q
);
  logic [N_OUT-1:0] nxt;

  for (genvar i = 0; i < N_OUT; i++) begin : g_bit
    always_comb begin
      case (mode)
        MODE_WRITE: nxt[i] = sel[i] ? d : q[i];
        MODE_DEMUX: nxt[i] = sel[i] & d;
        MODE_CLEAR: nxt[i] = 1'b0;
        default:    nxt[i] = q[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/addrlatch_addr_watch.sv
module addrlatch_addr_watch
  import addrlatch_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              addr_err
);
  logic [ADDR_W-1:0] prev_addr;
  logic              prev_vld;
  logic              jump;

  assign jump = prev_vld && multi_bit(32'(addr ^ prev_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr <= '0;
      prev_vld  <= 1'b0;
      addr_err  <= 1'b0;
    end else begin
      prev_addr <= addr;
      prev_vld  <= 1'b1;
      addr_err  <= !en_n && jump;
    end
  end
endmodule

// File: rtl/addrlatch_demux.sv
module addrlatch_demux
  import addrlatch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int N_OUT = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              d,
  output logic [N_OUT-1:0]  q,
  output logic              addr_err
);
  mode_e            mode;
  logic [N_OUT-1:0] sel;

  assign mode = decode_mode(en_n, clr_n);

  addrlatch_sel_dec #(.ADDR_W(ADDR_W)) u_sel (
    .addr (addr),
    .sel  (sel)
  );

  addrlatch_store #(.N_OUT(N_OUT)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .sel   (sel),
    .d     (d),
    .q     (q)
  );

  addrlatch_addr_watch #(.ADDR_W(ADDR_W)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_n     (en_n),
    .addr     (addr),
    .addr_err (addr_err)
  );
endmodule

// File: rtl/addrlatch_chk.sv
module addrlatch_chk #(
  parameter int ADDR_W = 3,
  localparam int N_OUT = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_n,
  input logic              clr_n,
  input logic [ADDR_W-1:0] addr,
  input logic              d,
  input logic [N_OUT-1:0]  q,
  input logic              addr_err
);
  localparam logic [N_OUT-1:0] ONE = {{(N_OUT-1){1'b0}}, 1'b1};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (q == '0 && !addr_err));

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && clr_n) |=> (q == $past(q)));

  // R3
  write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && clr_n) |=> (q[$past(addr)] == $past(d)));

  // R3
  write_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && clr_n) |=> (((q ^ $past(q)) & ~(ONE << $past(addr))) == '0));

  // R4
  demux_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !clr_n) |=> ($onehot0(q) && q[$past(addr)] == $past(d)));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && !clr_n) |=> (q == '0));

  // R9
  err_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> $past(!en_n));

  // R9
  err_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && $countones(addr ^ $past(addr)) <= 1) |=> !addr_err);
endmodule

bind addrlatch_demux addrlatch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_n     (en_n),
  .clr_n    (clr_n),
  .addr     (addr),
  .d        (d),
  .q        (q),
  .addr_err (addr_err)
);

// File: tb/test_addrlatch_demux.sv
`timescale 1ns/1ps
module test_addrlatch_demux;
  localparam int AW = 3;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_n = 1'b1;
  logic          clr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          d = 1'b0;
  logic [NB-1:0] q;
  logic          addr_err;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addrlatch_demux #(.ADDR_W(AW)) i_addrlatch_demux (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .clr_n(clr_n),
    .addr(addr), .d(d), .q(q), .addr_err(addr_err)
  );

  typedef struct {
    logic [NB-1:0] q;
    logic          err;
    string         tag;
  } exp_t;

  exp_t sb[$];

  // reference state
  logic [NB-1:0] m_q = '0;
  logic [AW-1:0] m_prev = '0;
  bit            m_vld = 1'b0;

  function automatic int diff_bits(input logic [AW-1:0] a, input logic [AW-1:0] b);
    int n = 0;
    for (int i = 0; i < AW; i++) if (a[i] != b[i]) n++;
    return n;
  endfunction

  // drive one cycle of stimulus and queue the expected result
  task automatic step(input logic r, input logic e, input logic c,
                      input logic [AW-1:0] a, input logic dv, input string tag);
    exp_t it;
    logic nerr;
    @(negedge clk);
    rst_n = r; en_n = e; clr_n = c; addr = a; d = dv;
    #1;
    tests++;
    if (q !== m_q) begin
      fails++;
      $display("FAIL R7 q moved before edge: got %h exp %h", q, m_q);
    end
    nerr = 1'b0;
    if (!r) begin
      m_q = '0; m_vld = 1'b0;
    end else begin
      nerr = !e && m_vld && (diff_bits(a, m_prev) >= 2);
      m_vld = 1'b1;
      if (!e && c)       m_q[a] = dv;
      else if (!e && !c) begin m_q = '0; m_q[a] = dv; end
      else if (e && !c)  m_q = '0;
    end
    m_prev = a;
    it.q = m_q; it.err = nerr; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare just after each rising edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      tests++;
      if (q !== it.q) begin
        fails++;
        $display("FAIL %s q: got %h exp %h", it.tag, q, it.q);
      end
      tests++;
      if (addr_err !== it.err) begin
        fails++;
        $display("FAIL R9 addr_err (%s step): got %b exp %b", it.tag, addr_err, it.err);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset with write mode active and data high
    step(1'b0, 1'b0, 1'b1, 3'd5, 1'b1, "R1");
    step(1'b0, 1'b0, 1'b0, 3'd2, 1'b1, "R1");
    // R3/R6: write 8'hA5 bit by bit, hold between to change address
    for (int k = 0; k < NB; k++) begin
      step(1'b1, 1'b1, 1'b1, AW'(k), 1'b0, "R2");
      step(1'b1, 1'b0, 1'b1, AW'(k), (8'hA5 >> k) & 1'b1, "R6");
    end
    // R2: hold ignores address and data
    step(1'b1, 1'b1, 1'b1, 3'd3, 1'b1, "R2");
    step(1'b1, 1'b1, 1'b1, 3'd6, 1'b0, "R2");
    // R3: overwrite single bits
    step(1'b1, 1'b1, 1'b1, 3'd1, 1'b1, "R2");
    step(1'b1, 1'b0, 1'b1, 3'd1, 1'b1, "R3");
    step(1'b1, 1'b0, 1'b1, 3'd1, 1'b0, "R3");
    step(1'b1, 1'b1, 1'b1, 3'd7, 1'b0, "R2");
    step(1'b1, 1'b0, 1'b1, 3'd7, 1'b0, "R6");
    // R4: demultiplex
    step(1'b1, 1'b1, 1'b1, 3'd3, 1'b0, "R2");
    step(1'b1, 1'b0, 1'b0, 3'd3, 1'b1, "R4");
    step(1'b1, 1'b0, 1'b0, 3'd3, 1'b0, "R4");
    step(1'b1, 1'b0, 1'b0, 3'd3, 1'b1, "R4");
    // R8: hold and write start from demux pattern
    step(1'b1, 1'b1, 1'b1, 3'd6, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b1, 3'd6, 1'b1, "R8");
    // R5: clear ignores address and data
    step(1'b1, 1'b1, 1'b0, 3'd6, 1'b1, "R5");
    step(1'b1, 1'b1, 1'b1, 3'd0, 1'b1, "R2");
    step(1'b1, 1'b0, 1'b1, 3'd0, 1'b1, "R3");
    // R9: multi-bit moves with enable low, single-bit moves, enable high
    step(1'b1, 1'b0, 1'b1, 3'd3, 1'b1, "R9");
    step(1'b1, 1'b0, 1'b1, 3'd2, 1'b0, "R9");
    step(1'b1, 1'b0, 1'b0, 3'd5, 1'b1, "R9");
    step(1'b1, 1'b1, 1'b1, 3'd2, 1'b1, "R9");
    step(1'b1, 1'b1, 1'b1, 3'd5, 1'b1, "R9");
    step(1'b1, 1'b0, 1'b1, 3'd4, 1'b0, "R9");
    // R1: reset mid-run while clear inactive
    step(1'b0, 1'b1, 1'b1, 3'd7, 1'b1, "R1");
    step(1'b1, 1'b0, 1'b1, 3'd0, 1'b1, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule